// File: doc/BRIEF.md
# Selectable Counting Clock Source

This block creates the count pulse for a two-digit BCD minutes or seconds counter on a board with a 25.175 MHz oscillator. A chain of terminal-count dividers brings the oscillator down to a 200 Hz base tick. A second stage turns that into a fast 20 Hz rate, and a third stage turns that into a slow 1 Hz rate. A switch picks which of the two rates drives the counter. A second switch hands the count over to an active-low push-button instead. A third switch decides whether the button is used raw, through a synchroniser and an edge detector, or cleaned by a debouncing state machine.

Every result is a single-cycle clock enable in the oscillator domain. No derived clock leaves the block. Two indicator outputs are provided. One is a square wave at the slow rate. The other lights while the synchronised button is held.

Top module: `cnt_clk_source`

## Requirements
- R1: While `rst_ni` is low, `count_en_o`, `led_1hz_o` and `led_manual_o` are all 0. After reset is released, with the internal source and the fast rate selected, the first enable appears BASE_DIV*FAST_DIV cycles after the first rising edge that sees reset high.
- R2: With `manual_sel_i`=0 and `fast_sel_i`=1, `count_en_o` pulses for exactly one cycle at every multiple of BASE_DIV*FAST_DIV cycles counted from reset release.
- R3: With `manual_sel_i`=0 and `fast_sel_i`=0, `count_en_o` pulses at every multiple of BASE_DIV*FAST_DIV*SLOW_DIV cycles counted from reset release. Every slow pulse coincides with a fast pulse.
- R4: `led_1hz_o` starts at 0 and inverts every BASE_DIV*FAST_DIV*SLOW_DIV/2 cycles, so its period is one slow interval. SLOW_DIV must be even. The LED runs whatever the switches select.
- R5: With `manual_sel_i`=0 the button has no effect on `count_en_o`. With `manual_sel_i`=1 no internal rate reaches `count_en_o`.
- R6: With `manual_sel_i`=1 and `filter_sel_i`=0, every high-to-low transition of `btn_ni` that survives the two-flop synchroniser yields one enable. That enable comes three cycles after the first clock edge that samples the low level. A bouncing contact therefore yields several enables.
- R7: With `manual_sel_i`=1 and `filter_sel_i`=1, a press yields exactly one enable. It is issued in the cycle after the DB_TICKS-th base tick that occurs while the synchronised button has stayed low since the debouncer armed.
- R8: In filtered mode, press bounces shorter than DB_TICKS base ticks restart the wait and produce no enable. Release bounces during a held press produce no enable.
- R9: `led_manual_o` is 1 while the synchronised button is held. It follows `btn_ni` with two cycles of latency, whatever the switches select.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oscillator clock (25.175 MHz nominal) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_ni | input | 1 | Push-button, low while pressed, asynchronous |
| fast_sel_i | input | 1 | 1 selects the fast internal rate, 0 the slow one |
| manual_sel_i | input | 1 | 1 selects the push-button, 0 the internal divider |
| filter_sel_i | input | 1 | 1 uses the debounced button, 0 the raw button edge |
| count_en_o | output | 1 | One-cycle count enable for the BCD counter |
| led_1hz_o | output | 1 | Square wave at the slow rate for an LED |
| led_manual_o | output | 1 | High while the synchronised button is held |

## Verification
The bench predicts the exact cycle of every enable. It drives both rates, switches between rates and sources mid-run, and bounces the button on press and on release in both manual modes. It also presses the button in internal mode, and gives a filtered press that is one sample tick too short. A divider whose terminal value is off by one shows up as drifting enable cycles. If the raw path were debounced, or the filter let bounces through, the enable count would differ from the queue. A debouncer that treated release bounce as a new press, or failed to restart on a press bounce, would issue enables that the scoreboard does not expect.

// File: rtl/cksrc_pkg.sv
package cksrc_pkg;

  typedef enum logic [1:0] {
    DB_IDLE,
    DB_ARM,
    DB_HELD,
    DB_DISARM
  } db_state_e;

  // Next value of a modulo-limit counter.
  function automatic int unsigned wrap_next(int unsigned cur, int unsigned limit);
    return (cur + 1 >= limit) ? 0 : cur + 1;
  endfunction

  // True when the counter sits on its terminal value.
  function automatic logic at_last(int unsigned cur, int unsigned limit);
    return cur == limit - 1;
  endfunction

endpackage

// File: rtl/tc_divider.sv
module tc_divider #(
  parameter int unsigned N = 10
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic step_i,
  output logic tick_o,
  output logic mid_o
);
  import cksrc_pkg::*;

  localparam int unsigned W = (N > 1) ? $clog2(N) : 1;

  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (step_i) begin
      cnt_q <= W'(wrap_next(32'(cnt_q), N));
    end
  end

  // terminal tick and halfway tick, both qualified by the incoming step
  assign tick_o = step_i && at_last(32'(cnt_q), N);
  assign mid_o  = step_i && (32'(cnt_q) == N / 2 - 1);

endmodule

// File: rtl/btn_sync.sv
module btn_sync (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  output logic pressed_o,
  output logic press_edge_o
);
  logic s1_q, s2_q, prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      s1_q   <= 1'b1;
      s2_q   <= 1'b1;
      prev_q <= 1'b0;
    end else begin
      s1_q   <= btn_ni;
      s2_q   <= s1_q;
      prev_q <= ~s2_q;
    end
  end

  assign pressed_o    = ~s2_q;
  assign press_edge_o = ~s2_q & ~prev_q;

endmodule

// File: rtl/btn_debounce.sv
module btn_debounce #(
  parameter int unsigned DB_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic pressed_i,
  input  logic sample_i,
  output logic pulse_o
);
  import cksrc_pkg::*;

  localparam int unsigned CW = $clog2(DB_TICKS + 1);

  db_state_e state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic pulse;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    pulse   = 1'b0;
    unique case (state_q)
      DB_IDLE: begin
        if (pressed_i) begin
          state_d = DB_ARM;
          cnt_d   = '0;
        end
      end
      DB_ARM: begin
        if (!pressed_i) begin
          state_d = DB_IDLE;
        end else if (sample_i) begin
          if (at_last(32'(cnt_q), DB_TICKS)) begin
            state_d = DB_HELD;
            cnt_d   = '0;
            pulse   = 1'b1;
          end else begin
            cnt_d = CW'(wrap_next(32'(cnt_q), DB_TICKS));
          end
        end
      end
      DB_HELD: begin
        if (!pressed_i) begin
          state_d = DB_DISARM;
          cnt_d   = '0;
        end
      end
      DB_DISARM: begin
        if (pressed_i) begin
          state_d = DB_HELD;
        end else if (sample_i) begin
          if (at_last(32'(cnt_q), DB_TICKS)) begin
            state_d = DB_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = CW'(wrap_next(32'(cnt_q), DB_TICKS));
          end
        end
      end
      default: state_d = DB_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= DB_IDLE;
      cnt_q   <= '0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
    end
  end

  assign pulse_o = pulse;

endmodule

// File: rtl/cnt_clk_source.sv
module cnt_clk_source #(
  parameter int unsigned BASE_DIV = 125875,
  parameter int unsigned FAST_DIV = 10,
  parameter int unsigned SLOW_DIV = 20,
  parameter int unsigned DB_TICKS = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic btn_ni,
  input  logic fast_sel_i,
  input  logic manual_sel_i,
  input  logic filter_sel_i,
  output logic count_en_o,
  output logic led_1hz_o,
  output logic led_manual_o
);

  // named internal events, also observed by the bound checker
  logic tick_base, tick_fast, tick_slow, half_slow;
  logic pressed_sync, raw_edge, db_pulse;
  logic unused_mid_base, unused_mid_fast;
  logic sel_tick;
  logic en_q, led_q;

  tc_divider #(.N(BASE_DIV)) u_base (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(1'b1),
    .tick_o(tick_base), .mid_o(unused_mid_base)
  );

  tc_divider #(.N(FAST_DIV)) u_fast (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(tick_base),
    .tick_o(tick_fast), .mid_o(unused_mid_fast)
  );

  tc_divider #(.N(SLOW_DIV)) u_slow (
    .clk_i(clk_i), .rst_ni(rst_ni), .step_i(tick_fast),
    .tick_o(tick_slow), .mid_o(half_slow)
  );

  btn_sync u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .btn_ni(btn_ni),
    .pressed_o(pressed_sync), .press_edge_o(raw_edge)
  );

  btn_debounce #(.DB_TICKS(DB_TICKS)) u_db (
    .clk_i(clk_i), .rst_ni(rst_ni), .pressed_i(pressed_sync),
    .sample_i(tick_base), .pulse_o(db_pulse)
  );

  always_comb begin
    if (manual_sel_i) sel_tick = filter_sel_i ? db_pulse : raw_edge;
    else              sel_tick = fast_sel_i ? tick_fast : tick_slow;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= 1'b0;
      led_q <= 1'b0;
    end else begin
      en_q <= sel_tick;
      if (half_slow || tick_slow) led_q <= ~led_q;
    end
  end

  assign count_en_o   = en_q;
  assign led_1hz_o    = led_q;
  assign led_manual_o = pressed_sync;

endmodule

// File: rtl/cnt_clk_source_chk.sv
module cnt_clk_source_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic fast_sel_i,
  input logic manual_sel_i,
  input logic filter_sel_i,
  input logic count_en_o,
  input logic led_1hz_o,
  input logic tick_fast,
  input logic tick_slow,
  input logic raw_edge,
  input logic db_pulse,
  input logic pressed_sync
);

  AST_EN_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    count_en_o |=> !count_en_o); // R2

  AST_FAST_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!manual_sel_i && fast_sel_i && tick_fast) |=> count_en_o); // R2

  AST_SLOW_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!manual_sel_i && !fast_sel_i && tick_slow) |=> count_en_o); // R3

  AST_SLOW_ON_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_slow |-> tick_fast); // R3

  AST_LED_MOVES_ON_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(led_1hz_o) |-> $past(tick_fast)); // R4

  AST_MANUAL_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (manual_sel_i && !raw_edge && !db_pulse) |=> !count_en_o); // R5

  AST_RAW_FORWARD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (manual_sel_i && !filter_sel_i && raw_edge) |=> count_en_o); // R6

  AST_DB_WHILE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    db_pulse |-> pressed_sync); // R7

endmodule

bind cnt_clk_source cnt_clk_source_chk u_chk (
  .clk_i(clk_i),
  .rst_ni(rst_ni),
  .fast_sel_i(fast_sel_i),
  .manual_sel_i(manual_sel_i),
  .filter_sel_i(filter_sel_i),
  .count_en_o(count_en_o),
  .led_1hz_o(led_1hz_o),
  .tick_fast(tick_fast),
  .tick_slow(tick_slow),
  .raw_edge(raw_edge),
  .db_pulse(db_pulse),
  .pressed_sync(pressed_sync)
);

// File: tb/test_cnt_clk_source.sv
`timescale 1ns/1ps
module test_cnt_clk_source;

  localparam int BASE = 4;
  localparam int FAST = 3;
  localparam int SLOW = 4;
  localparam int DB   = 3;
  localparam int PF   = BASE * FAST;
  localparam int PS   = PF * SLOW;
  localparam int HALF = PS / 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic btn_n = 1'b1;
  logic fast_sel = 1'b1;
  logic manual_sel = 1'b0;
  logic filter_sel = 1'b0;
  logic count_en, led_1hz, led_manual;

  int cyc = 0;
  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;
  int exp_q[$];
  string tag_q[$];

  always #5 clk = ~clk;

  cnt_clk_source #(
    .BASE_DIV(BASE), .FAST_DIV(FAST), .SLOW_DIV(SLOW), .DB_TICKS(DB)
  ) i_cnt_clk_source (
    .clk_i(clk), .rst_ni(rst_n), .btn_ni(btn_n),
    .fast_sel_i(fast_sel), .manual_sel_i(manual_sel), .filter_sel_i(filter_sel),
    .count_en_o(count_en), .led_1hz_o(led_1hz), .led_manual_o(led_manual)
  );

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(bit ok, string req, int act, int exp);
    n_checks++;
    if (!ok) begin
      n_errors++;
      $display("FAIL %s at cycle %0d: actual=%0d expected=%0d", req, cyc, act, exp);
    end
  endtask

  task automatic push(int c, string req);
    exp_q.push_back(c);
    tag_q.push_back(req);
  endtask

  // internal-rate enables expected in (from, to]
  task automatic expect_rate(int period, int from, int to, string req);
    for (int c = from + 1; c <= to; c++)
      if (c % period == 0) push(c, req);
  endtask

  // debounced enable for a final press driven at the negedge of cycle n
  function automatic int db_expect(int n);
    int t = n + 3;
    int k = 0;
    while (1) begin
      if (t % BASE == BASE - 1) k++;
      if (k == DB) return t + 1;
      t++;
    end
  endfunction

  task automatic goto(int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic end_segment(string req);
    check(exp_q.size() == 0, req, exp_q.size(), 0);
    exp_q.delete();
    tag_q.delete();
  endtask

  // monitor: every enable must match the head of the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (count_en) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R5/R8 unexpected enable", cyc, -1);
        end else begin
          automatic int e = exp_q.pop_front();
          automatic string r = tag_q.pop_front();
          check(e == cyc, r, cyc, e);
        end
      end
      check(led_1hz == (((cyc / HALF) % 2) == 1), "R4",
            int'(led_1hz), (cyc / HALF) % 2);
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(count_en == 1'b0, "R1", int'(count_en), 0);
    check(led_1hz == 1'b0, "R1", int'(led_1hz), 0);
    check(led_manual == 1'b0, "R1", int'(led_manual), 0);
    rst_n = 1'b1;

    // fast rate from reset
    push(PF, "R1");
    expect_rate(PF, PF, 62, "R2");
    goto(62);
    end_segment("R2");

    // slow rate, button pressed meanwhile and ignored
    fast_sel = 1'b0;
    expect_rate(PS, 62, 200, "R3");
    goto(100); btn_n = 1'b0;
    goto(130); btn_n = 1'b1;
    goto(200);
    end_segment("R5");

    // raw push-button with press bounce
    manual_sel = 1'b1; filter_sel = 1'b0;
    goto(210); btn_n = 1'b0; push(213, "R6");
    goto(211); check(led_manual == 1'b0, "R9", int'(led_manual), 0);
    goto(212); check(led_manual == 1'b1, "R9", int'(led_manual), 1);
    btn_n = 1'b1;
    goto(214); btn_n = 1'b0; push(217, "R6");
    goto(216); btn_n = 1'b1;
    goto(218); btn_n = 1'b0; push(221, "R6");
    goto(240); btn_n = 1'b1;
    goto(243); check(led_manual == 1'b0, "R9", int'(led_manual), 0);
    goto(260);
    end_segment("R6");

    // filtered: press bounce, then stable press
    filter_sel = 1'b1;
    goto(270); btn_n = 1'b0;
    goto(272); btn_n = 1'b1;
    goto(274); btn_n = 1'b0;
    goto(276); btn_n = 1'b1;
    goto(278); btn_n = 1'b0; push(db_expect(278), "R7");
    // release bounce while held
    goto(300); btn_n = 1'b1;
    goto(302); btn_n = 1'b0;
    goto(304); btn_n = 1'b1;
    goto(330); btn_n = 1'b0; push(db_expect(330), "R7");
    goto(360); btn_n = 1'b1;
    // press one sample tick too short
    goto(380); btn_n = 1'b0;
    goto(386); btn_n = 1'b1;
    goto(400);
    end_segment("R8");

    // back to the internal fast rate
    manual_sel = 1'b0; fast_sel = 1'b1;
    expect_rate(PF, 400, 450, "R5");
    goto(450);
    end_segment("R5");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
    $finish;
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      done = 1'b1;
      n_checks++;
      n_errors++;
      $display("FAIL watchdog at cycle %0d: actual=1 expected=0", cyc);
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
    end
  end

endmodule